// File: doc/BRIEF.md
# Wrapping Time Histogram Accumulator

This block builds a histogram of arrival times. Each incoming item is a bin index: the number of the sample interval within an acquisition cycle in which a detection happened. The block reads the addressed bin, adds one and writes the result back. A dedicated pipeline stage forwards the result, so hits to the same bin can arrive on every clock. Counts build up over every cycle of a run and are not zeroed between cycles. Only an explicit clear zeroes them, and the clear walks through the bins at one bin per clock.

An early part of each cycle can be masked. A hit whose index is below the suppress limit is still accepted on the stream but is not counted. Every bin is a 16-bit counter that deliberately wraps to zero on overflow. Software extends the counts to a wider range between runs.

A host reads single bins through a read port with a fixed latency of two clocks. The port is closed while a measurement is in progress and while a clear runs. The bin address width is a parameter: 15 gives the full 32k-bin histogram, and the default is smaller to keep elaboration light. Bin contents are undefined after power-up until the first clear.

Top module: `hist_accum`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and `hit_ready` is 1.
- R2: Each accepted hit (`hit_valid` and `hit_ready` both 1 at a rising edge) with `hit_bin >= supp_lim` increments bin `hit_bin` by exactly one.
- R3: An accepted hit with `hit_bin < supp_lim` changes no bin. A hit with `hit_bin == supp_lim` is counted.
- R4: Hits to the same bin on consecutive clocks, including interleaved patterns such as A,A,B,A,B,B, are all counted, and none is lost.
- R5: A bin holding 16'hFFFF that receives one more hit holds 16'h0000.
- R6: Bin counts persist across toggles of `mip` and across any number of runs, until a clear.
- R7: A `clr_req` seen while `busy` is 0 raises `busy` at the next edge. `busy` stays high for exactly 2**BIN_AW clocks, and afterwards every bin reads 0.
- R8: `hit_ready` is 0 while `busy` is 1. Hits offered during a clear are not taken and change no bin.
- R9: A read request (`rd_en` at an edge while `mip` and `busy` are 0) makes `rd_valid` 1 after the second following edge, with `rd_data` equal to the addressed bin.
- R10: A read request while `mip` is 1 is ignored: `rd_valid` stays 0 and `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A bin index is offered |
| hit_ready | output | 1 | The block can accept a bin index |
| hit_bin | input | BIN_AW | Sample interval index of the hit |
| supp_lim | input | BIN_AW | Indices below this value are discarded |
| mip | input | 1 | Measurement in progress; blocks host reads |
| clr_req | input | 1 | Request to zero every bin |
| busy | output | 1 | A clear is running |
| rd_en | input | 1 | Host read request |
| rd_addr | input | BIN_AW | Bin to read |
| rd_data | output | CNT_W | Count of the bin that was read |
| rd_valid | output | 1 | `rd_data` holds a new result this cycle |

## Verification
The bench sends same-bin bursts and interleaved patterns. A design without working forwarding would lose increments and read back a count that is too low. One bin is driven through 65536 hits and then a few more. A saturating design would stay at 16'hFFFF, and a wider counter would carry into bits that should not exist. Hits are placed just below and exactly on the suppress limit to expose an off-by-one compare. Reads are issued under `mip` to catch a port that leaks data or a spurious `rd_valid`. Hits offered during a clear are checked, which would show a clear that leaves the stream open or one that is one clock short.

// File: rtl/hist_pkg.sv
package hist_pkg;
   localparam int CNT_W = 16;
   typedef logic [CNT_W-1:0] cnt_t;
   typedef enum logic {CLR_IDLE, CLR_RUN} clr_st_e;
endpackage

// File: rtl/hist_mem.sv
module hist_mem #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [DW-1:0] ra_data,
   input  logic          rb_en,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] rb_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      ra_data <= store[ra_addr];
      if (rb_en) rb_data <= store[rb_addr];
   end
endmodule

// File: rtl/hist_upd.sv
module hist_upd
   import hist_pkg::*;
#(
   parameter int AW      = 10,
   parameter bit SUPP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_fire,
   input  logic [AW-1:0] in_bin,
   input  logic [AW-1:0] supp_lim,
   input  cnt_t          mem_rdata,
   output logic          wr_v,
   output logic [AW-1:0] wr_addr,
   output cnt_t          wr_data
);
   logic          keep;
   logic          s1_v;
   logic [AW-1:0] s1_addr;
   logic          s1_fwd;
   cnt_t          s1_fwd_val;
   cnt_t          cur;
   cnt_t          sum;

   generate
      if (SUPP_EN) begin : g_supp
         assign keep = in_fire && (in_bin >= supp_lim);
      end else begin : g_nosupp
         assign keep = in_fire;
      end
   endgenerate

   assign cur = s1_fwd ? s1_fwd_val : mem_rdata;
   assign sum = cur + cnt_t'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v       <= 1'b0;
         s1_addr    <= '0;
         s1_fwd     <= 1'b0;
         s1_fwd_val <= '0;
      end else begin
         s1_v       <= keep;
         s1_addr    <= in_bin;
         s1_fwd     <= keep && s1_v && (s1_addr == in_bin);
         s1_fwd_val <= sum;
      end
   end

   assign wr_v    = s1_v;
   assign wr_addr = s1_addr;
   assign wr_data = sum;
endmodule

// File: rtl/hist_clr.sv
module hist_clr
   import hist_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   output logic          busy,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = {AW{1'b1}};

   clr_st_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= CLR_IDLE;
         addr <= '0;
      end else begin
         case (st)
            CLR_IDLE: if (req) begin
               st   <= CLR_RUN;
               addr <= '0;
            end
            CLR_RUN: begin
               addr <= addr + 1'b1;
               if (addr == LAST) st <= CLR_IDLE;
            end
            default: st <= CLR_IDLE;
         endcase
      end
   end

   assign busy = (st == CLR_RUN);
endmodule

// File: rtl/hist_accum.sv
module hist_accum
   import hist_pkg::*;
#(
   parameter int BIN_AW  = 10,
   parameter bit SUPP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_valid,
   output logic              hit_ready,
   input  logic [BIN_AW-1:0] hit_bin,
   input  logic [BIN_AW-1:0] supp_lim,
   input  logic              mip,
   input  logic              clr_req,
   output logic              busy,
   input  logic              rd_en,
   input  logic [BIN_AW-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              rd_valid
);
   generate
      if (BIN_AW < 1 || BIN_AW > 15) begin : g_bad_aw
         $error("hist_accum: BIN_AW must lie in 1..15");
      end
   endgenerate

   logic              fire;
   logic              upd_wr_v;
   logic [BIN_AW-1:0] upd_wr_addr;
   cnt_t              upd_wr_data;
   logic [BIN_AW-1:0] clr_addr;
   logic              mem_we;
   logic [BIN_AW-1:0] mem_waddr;
   cnt_t              mem_wdata;
   cnt_t              ra_data;
   cnt_t              rb_data;
   logic              rb_en;
   logic              rd_p1;

   assign hit_ready = !busy;
   assign fire      = hit_valid && hit_ready;
   assign rb_en     = rd_en && !mip && !busy;

   assign mem_we    = busy || upd_wr_v;
   assign mem_waddr = busy ? clr_addr : upd_wr_addr;
   assign mem_wdata = busy ? '0 : upd_wr_data;

   hist_clr #(.AW(BIN_AW)) u_clr (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (clr_req),
      .busy (busy),
      .addr (clr_addr)
   );

   hist_upd #(.AW(BIN_AW), .SUPP_EN(SUPP_EN)) u_upd (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_fire  (fire),
      .in_bin   (hit_bin),
      .supp_lim (supp_lim),
      .mem_rdata(ra_data),
      .wr_v     (upd_wr_v),
      .wr_addr  (upd_wr_addr),
      .wr_data  (upd_wr_data)
   );

   hist_mem #(.AW(BIN_AW), .DW(CNT_W)) u_mem (
      .clk    (clk),
      .we     (mem_we),
      .waddr  (mem_waddr),
      .wdata  (mem_wdata),
      .ra_addr(hit_bin),
      .ra_data(ra_data),
      .rb_en  (rb_en),
      .rb_addr(rd_addr),
      .rb_data(rb_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_p1    <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_p1    <= rb_en;
         rd_valid <= rd_p1;
         if (rd_p1) rd_data <= rb_data;
      end
   end
endmodule

// File: rtl/hist_accum_chk.sv
module hist_accum_chk
   import hist_pkg::*;
#(
   parameter int BIN_AW = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hit_valid,
   input logic              hit_ready,
   input logic [BIN_AW-1:0] hit_bin,
   input logic [BIN_AW-1:0] supp_lim,
   input logic              mip,
   input logic              clr_req,
   input logic              busy,
   input logic              rd_en,
   input logic [BIN_AW-1:0] rd_addr,
   input logic [CNT_W-1:0]  rd_data,
   input logic              rd_valid
);
   localparam int DEPTH = 1 << BIN_AW;

   logic [BIN_AW:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else bcnt <= '0;
   end

   AST_READY_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !hit_ready); // R8
   AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !busy) |=> busy); // R7
   AST_CLEAR_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (bcnt == (BIN_AW+1)'(DEPTH))); // R7
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mip && !busy) |=> ##1 rd_valid); // R9
   AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mip) |=> ##1 !rd_valid); // R10
endmodule

bind hist_accum hist_accum_chk #(.BIN_AW(BIN_AW)) u_chk (.*);

// File: tb/tb_hist_accum.sv
module tb_hist_accum;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_valid = 1'b0;
   logic          hit_ready;
   logic [AW-1:0] hit_bin = '0;
   logic [AW-1:0] supp_lim = '0;
   logic          mip = 1'b0;
   logic          clr_req = 1'b0;
   logic          busy;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;
   logic          rd_valid;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   int model [DEPTH];
   int q_val [$];
   int q_cyc [$];
   string q_req [$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hist_accum dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hit(input int bin);
      hit_valid = 1'b1;
      hit_bin   = AW'(bin);
      if (hit_ready && bin >= int'(supp_lim)) model[bin] = (model[bin] + 1) & 16'hFFFF;
      @(negedge clk);
   endtask

   task automatic hit_stop();
      hit_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(input int addr, input string req);
      rd_en   = 1'b1;
      rd_addr = AW'(addr);
      q_val.push_back(model[addr]);
      q_cyc.push_back(cyc + 2);
      q_req.push_back(req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_drain();
      rd_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_clear();
      int n;
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      chk(busy === 1'b1, "R7 busy after request", int'(busy), 1);
      n = 0;
      while (busy === 1'b1 && n < DEPTH + 10) begin
         n++;
         @(negedge clk);
      end
      chk(n == DEPTH, "R7 clear length", n, DEPTH);
      foreach (model[i]) model[i] = 0;
   endtask

   // monitor: pops expected reads as results appear
   always @(negedge clk) begin
      if (rst_n && rd_valid === 1'b1) begin
         if (q_val.size() == 0) begin
            chk(1'b0, "R10 unexpected rd_valid", 1, 0);
         end else begin
            int ev, ec;
            string er;
            ev = q_val.pop_front();
            ec = q_cyc.pop_front();
            er = q_req.pop_front();
            chk(int'(rd_data) == ev && rd_data !== 'x, er, int'(rd_data), ev);
            chk(cyc == ec, "R9 read latency", cyc, ec);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (model[i]) model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(busy === 1'b0, "R1 busy", int'(busy), 0);
      chk(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
      chk(hit_ready === 1'b1, "R1 hit_ready", int'(hit_ready), 1);

      // R7 clear, with hits offered during it (R8)
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      hit_valid = 1'b1;
      hit_bin = AW'(5);
      @(negedge clk);
      chk(hit_ready === 1'b0, "R8 ready low in clear", int'(hit_ready), 0);
      while (busy === 1'b1) @(negedge clk);
      hit_valid = 1'b0;
      foreach (model[i]) model[i] = 0;
      repeat (3) @(negedge clk);
      rd(5, "R8 hit during clear ignored");
      for (int a = 0; a < DEPTH; a += 37) rd(a, "R7 bin zero after clear");
      rd(DEPTH - 1, "R7 last bin zero");
      rd_drain();

      // R2 single hits, R6 across mip toggles
      mip = 1'b1;
      hit(3); hit_stop();
      hit(200); hit_stop();
      hit(DEPTH - 1); hit_stop();
      mip = 1'b0;
      rd(3, "R2 single hit");
      rd(200, "R2 single hit");
      rd(DEPTH - 1, "R2 top bin");
      rd_drain();
      mip = 1'b1;
      hit(3); hit(200); hit_stop();
      mip = 1'b0;
      rd(3, "R6 accumulates");
      rd(200, "R6 accumulates");
      rd_drain();

      // R10 read under mip
      mip = 1'b1;
      begin
         logic [15:0] held;
         held = rd_data;
         rd_en = 1'b1;
         rd_addr = AW'(3);
         @(negedge clk);
         rd_en = 1'b0;
         repeat (4) begin
            @(negedge clk);
            chk(rd_valid === 1'b0, "R10 no rd_valid", int'(rd_valid), 0);
            chk(rd_data === held, "R10 rd_data held", int'(rd_data), int'(held));
         end
      end
      mip = 1'b0;

      // R4 back-to-back and interleaved
      hit(10); hit(10); hit(11); hit(10); hit(11); hit(11);
      hit(12); hit(12); hit(12); hit(12);
      hit(13); hit(14); hit(13); hit(14);
      hit_stop();
      rd(10, "R4 interleaved A");
      rd(11, "R4 interleaved B");
      rd(12, "R4 same-bin burst");
      rd(13, "R4 alternating");
      rd(14, "R4 alternating");
      rd_drain();

      // R3 suppress boundary
      supp_lim = AW'(100);
      hit(99); hit(100); hit(0); hit(101); hit(99);
      hit_stop();
      rd(99, "R3 below limit ignored");
      rd(0, "R3 below limit ignored");
      rd(100, "R3 at limit counted");
      rd(101, "R3 above limit counted");
      rd_drain();
      supp_lim = '0;

      // R5 wrap
      for (int k = 0; k < 65536; k++) hit(7);
      hit_stop();
      rd(7, "R5 wrap to zero");
      rd_drain();
      hit(7); hit(7); hit(7);
      hit_stop();
      rd(7, "R5 count after wrap");
      rd_drain();

      // R7 clear after use
      do_clear();
      repeat (2) @(negedge clk);
      rd(3, "R7 cleared"); rd(10, "R7 cleared"); rd(100, "R7 cleared");
      rd(DEPTH - 1, "R7 cleared");
      rd_drain();

      chk(q_val.size() == 0, "R9 all reads returned", q_val.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule